// File: doc/BRIEF.md
# Sleep Mode Wake Controller

This block is the power-state controller for a small microcontroller. It records whether the core runs at full speed or at a reduced medium speed. On a sleep command it moves to the sleep state that matches that speed. In the medium-speed states it selects a clock divide ratio from a two-bit field. The clock gating cells and the CPU are outside the block and consume its outputs.

The block leaves sleep when an interrupt request arrives that is both enabled for its source and not masked by the CPU's global mask bit. It then returns to the active state with the same speed it had before sleeping, and pulses a strobe that starts exception handling. Interrupt requests arrive asynchronously and pass through a two-stage synchronizer. A low level on the reset input clears sleep at once, whatever the mask and enable bits hold.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and on release of reset, `mode` is 2'b00 (active, high speed), `wake_stb` is 0 and `div_sel` is 1.
- R2: In an active mode with `sleep_cmd` low, `mode` takes 2'b01 (active, medium) after the next rising edge if `speed_med` is 1, and 2'b00 if it is 0.
- R3: In an active mode, `sleep_cmd` high at a rising edge moves `mode` to the sleep state of the current speed: 2'b00 goes to 2'b10 and 2'b01 goes to 2'b11. The `speed_med` value in that cycle has no effect.
- R4: In a sleep mode (`mode[1]`=1), `sleep_cmd` and `speed_med` have no effect on `mode`.
- R5: A wake-up leaves sleep to the active state of the same speed: 2'b10 goes to 2'b00 and 2'b11 goes to 2'b01.
- R6: When a bit of `irq_req` rises between clock edges, `mode` changes and `wake_stb` rises at the third rising edge after the rise. The strobe is high for exactly one cycle.
- R7: A request does not wake the block while `imask` is 1, or while that source's `irq_en` bit is 0. A request held under the mask wakes the block at the first rising edge after `imask` returns to 0.
- R8: `div_sel` is 1 in the high-speed modes. In the medium-speed modes it is 16, 32, 64 or 128 for `ma_sel` values 00, 01, 10 and 11.
- R9: Driving `rst_n` low in a sleep mode returns `mode` to 2'b00 at once, even when `imask` is 1.
- R10: `wake_stb` stays 0 while the block is active, whatever requests arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_cmd | input | 1 | Sleep command from the CPU |
| speed_med | input | 1 | Speed request for the active state: 1 selects medium, 0 selects high |
| irq_req | input | N_SRC | Asynchronous interrupt requests, one bit per source |
| irq_en | input | N_SRC | Enable bit for each source |
| imask | input | 1 | Global interrupt mask bit of the CPU; 1 blocks wake-up |
| ma_sel | input | 2 | Selects the medium-speed divide ratio |
| mode | output | 2 | Power state: bit 1 means sleep, bit 0 means medium speed |
| div_sel | output | 8 | Divide ratio for the clock divider |
| wake_stb | output | 1 | One-cycle pulse that starts exception handling |

## Verification
A request that rises between edges is clocked through two synchronizer stages. The state register and the strobe register then update together on the third rising edge. The bench drives every input at a falling edge and samples at later falling edges. It checks that `mode` is still a sleep state two falling edges after the request and has changed by the third. It also checks that the strobe is high at that third sample and low at the fourth. Changes to `speed_med` and `sleep_cmd` are checked at the next falling edge. `div_sel` is decoded from the current state without a register, so the bench checks it in the same sample as `mode`. Reset is asynchronous, so the bench checks it shortly after `rst_n` falls, with no clock edge in between.

// File: rtl/slpw_pkg.sv
`timescale 1ns/1ps
package slpw_pkg;
  localparam int DIV_W = 8;

  // bit 1: sleeping, bit 0: medium speed
  typedef enum logic [1:0] {
    MODE_ACT_HI  = 2'b00,
    MODE_ACT_MED = 2'b01,
    MODE_SLP_HI  = 2'b10,
    MODE_SLP_MED = 2'b11
  } pwr_mode_e;

  // medium-speed divide ratio: 16 shifted left by the field value
  function automatic logic [DIV_W-1:0] med_ratio(input logic [1:0] ma);
    logic [DIV_W-1:0] base;
    base = DIV_W'(16);
    return base << ma;
  endfunction

  function automatic logic [DIV_W-1:0] div_for(input pwr_mode_e m, input logic [1:0] ma);
    return m[0] ? med_ratio(ma) : DIV_W'(1);
  endfunction
endpackage

// File: rtl/slpw_sync.sv
`timescale 1ns/1ps
module slpw_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= d_async[g];
        st2 <= st1;
      end
    end
    assign q_sync[g] = st2;
  end
endmodule

// File: rtl/slpw_wake.sv
`timescale 1ns/1ps
module slpw_wake #(
  parameter int N = 16
) (
  input  logic [N-1:0] req_s,
  input  logic [N-1:0] en,
  input  logic         imask,
  output logic         hit
);
  logic [N-1:0] qualified;
  assign qualified = req_s & en;
  assign hit       = (|qualified) & ~imask;
endmodule

// File: rtl/slpw_fsm.sv
`timescale 1ns/1ps
module slpw_fsm
  import slpw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_cmd,
  input  logic      speed_med,
  input  logic      wake_hit,
  output pwr_mode_e mode_q,
  output logic      wake_stb
);
  pwr_mode_e mode_d;
  logic      sleeping, leave_sleep;

  assign sleeping    = mode_q[1];
  assign leave_sleep = sleeping & wake_hit;

  always_comb begin
    mode_d = mode_q;
    if (sleeping) begin
      if (wake_hit) mode_d = pwr_mode_e'({1'b0, mode_q[0]});
    end else if (sleep_cmd) begin
      mode_d = pwr_mode_e'({1'b1, mode_q[0]});
    end else begin
      mode_d = pwr_mode_e'({1'b0, speed_med});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_ACT_HI;
      wake_stb <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      wake_stb <= leave_sleep;
    end
  end

  p_enter_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[1] && sleep_cmd) |=> (mode_q == {1'b1, $past(mode_q[0])}));

  p_sleep_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && !wake_hit) |=> $stable(mode_q));

  p_wake_speed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && wake_hit) |=> ((mode_q == {1'b0, $past(mode_q[0])}) && wake_stb));

  p_stb_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |=> !wake_stb);

  p_stb_only_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |-> !mode_q[1]);
endmodule

// File: rtl/sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sleep_wake_ctrl
  import slpw_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_cmd,
  input  logic             speed_med,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  input  logic             imask,
  input  logic [1:0]       ma_sel,
  output logic [1:0]       mode,
  output logic [DIV_W-1:0] div_sel,
  output logic             wake_stb
);
  logic [N_SRC-1:0] req_synced;
  logic             wake_hit;
  pwr_mode_e        mode_q;

  slpw_sync #(.W(N_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (irq_req),
    .q_sync  (req_synced)
  );

  slpw_wake #(.N(N_SRC)) u_wake (
    .req_s (req_synced),
    .en    (irq_en),
    .imask (imask),
    .hit   (wake_hit)
  );

  slpw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_cmd (sleep_cmd),
    .speed_med (speed_med),
    .wake_hit  (wake_hit),
    .mode_q    (mode_q),
    .wake_stb  (wake_stb)
  );

  assign mode    = mode_q;
  assign div_sel = div_for(mode_q, ma_sel);

  p_mask_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && imask) |=> mode[1]);

  p_div_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_sel) == 1);

  p_high_div_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[0] |-> (div_sel == DIV_W'(1)));
endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb_top;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sleep_cmd = 1'b0;
  logic         speed_med = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [N-1:0] irq_en = '1;
  logic         imask = 1'b0;
  logic [1:0]   ma_sel = 2'b00;
  logic [1:0]   mode;
  logic [7:0]   div_sel;
  logic         wake_stb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .speed_med(speed_med),
    .irq_req(irq_req), .irq_en(irq_en), .imask(imask), .ma_sel(ma_sel),
    .mode(mode), .div_sel(div_sel), .wake_stb(wake_stb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_div(input int m, input int ma);
    return (m % 2 == 1) ? (2 ** (4 + ma)) : 1;
  endfunction

  task automatic go_sleep(input bit med);
    speed_med = med;
    tick(1);
    chk("R2 active speed", int'(mode), int'(med));
    sleep_cmd = 1'b1;
    tick(1);
    sleep_cmd = 1'b0;
    chk("R3 sleep entry", int'(mode), 2 + int'(med));
  endtask

  task automatic drain();
    irq_req = '0;
    tick(3);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    chk("R1 mode in reset", int'(mode), 0);
    chk("R1 stb in reset", int'(wake_stb), 0);
    chk("R1 div in reset", int'(div_sel), 1);
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R1 mode after reset", int'(mode), 0);

    // R2 / R8: speed following and divider in active modes
    for (int ma = 0; ma < 4; ma++) begin
      ma_sel = 2'(ma);
      speed_med = 1'b1;
      tick(1);
      chk("R2 to medium", int'(mode), 1);
      chk("R8 active medium div", int'(div_sel), exp_div(1, ma));
      speed_med = 1'b0;
      tick(1);
      chk("R2 to high", int'(mode), 0);
      chk("R8 active high div", int'(div_sel), 1);
    end

    // R3: speed_med in the same cycle as sleep_cmd has no effect
    speed_med = 1'b0;
    tick(1);
    sleep_cmd = 1'b1;
    speed_med = 1'b1;
    tick(1);
    sleep_cmd = 1'b0;
    chk("R3 sleep keeps high speed", int'(mode), 2);
    // R4: commands ignored while sleeping
    sleep_cmd = 1'b1;
    tick(2);
    chk("R4 speed ignored in sleep", int'(mode), 2);
    speed_med = 1'b0;
    sleep_cmd = 1'b0;
    tick(2);
    chk("R4 still asleep", int'(mode), 2);
    irq_req = 16'h0001;
    tick(3);
    chk("R5 wake high", int'(mode), 0);
    tick(1);
    drain();

    // R5 / R6 / R8: every source, both speeds
    for (int med = 0; med < 2; med++) begin
      for (int i = 0; i < N; i++) begin
        ma_sel = 2'(i % 4);
        go_sleep(med[0]);
        chk("R8 sleep div", int'(div_sel), exp_div(2 + med, i % 4));
        irq_req = N'(1) << i;
        tick(2);
        chk("R6 still asleep after two edges", int'(mode), 2 + med);
        chk("R6 no early strobe", int'(wake_stb), 0);
        tick(1);
        chk("R5 wake to same speed", int'(mode), med);
        chk("R6 strobe on third edge", int'(wake_stb), 1);
        tick(1);
        chk("R6 strobe one cycle", int'(wake_stb), 0);
        drain();
      end
    end

    // R7: global mask, then per-source enable
    for (int i = 0; i < N; i++) begin
      go_sleep(i[0]);
      imask = 1'b1;
      irq_req = N'(1) << i;
      tick(5);
      chk("R7 masked stays asleep", int'(mode), 2 + (i % 2));
      chk("R7 masked no strobe", int'(wake_stb), 0);
      imask = 1'b0;
      tick(1);
      chk("R7 unmask wakes", int'(mode), i % 2);
      chk("R7 unmask strobe", int'(wake_stb), 1);
      drain();

      go_sleep(i[0]);
      irq_en = ~(N'(1) << i);
      irq_req = N'(1) << i;
      tick(5);
      chk("R7 disabled stays asleep", int'(mode), 2 + (i % 2));
      chk("R7 disabled no strobe", int'(wake_stb), 0);
      irq_req = N'(1) << ((i + 1) % N);
      tick(3);
      chk("R7 other enabled source wakes", int'(mode), i % 2);
      irq_en = '1;
      drain();
    end

    // R10: requests while active give no strobe
    speed_med = 1'b1;
    for (int i = 0; i < N; i++) begin
      irq_req = N'(1) << i;
      tick(1);
      chk("R10 no strobe when active", int'(wake_stb), 0);
    end
    drain();
    chk("R10 still active", int'(mode), 1);

    // R9: reset clears sleep despite mask
    go_sleep(1'b1);
    imask = 1'b1;
    tick(1);
    rst_n = 1'b0;
    #1;
    chk("R9 reset clears sleep", int'(mode), 0);
    chk("R9 div after reset", int'(div_sel), 1);
    tick(1);
    imask = 1'b0;
    speed_med = 1'b0;
    rst_n = 1'b1;
    tick(1);
    chk("R9 active high after reset", int'(mode), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule